// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits beside a small processor core and decides when the core leaves its normal flow to run an interrupt handler. It serves four request lines, where line 0 is the most urgent and line 3 the least. Each line has an enable bit and a handler address. The handler address is loaded through a write port that a set-vector instruction drives with a 2-bit line number and an address. The core reports the end of each instruction and its current program counter. At such a boundary the controller may order an entry: it emits a one-cycle pulse with the handler address, and it saves the program counter in a slot that belongs to that line.

Contexts nest. A running handler can be preempted only by a line of strictly higher priority, which means a smaller line number. Requests of equal or lower priority stay pending until the handler returns. A return strobe from the core closes the innermost context. The controller then emits a one-cycle pulse with the address saved for that context, so a series of returns walks back out through the nest. Requests are level-sensitive: a line that is still asserted after its handler returns is taken again at a later boundary. Saving the general registers is left to the software.

Top module: `prio_nest_intc`

## Requirements
- R1: During and right after a synchronous active-low reset, `take_pulse` and `ret_valid` are 0. No context is active, and every handler address and every saved address is 0.
- R2: When `vec_wr` is high at a clock edge, `vec_addr` is stored as the handler address of line `vec_sel`. An entry that happens at that same edge still uses the old handler address.
- R3: A line whose bit in `irq_en` is 0 is never entered, whatever the state of its `irq_req` bit.
- R4: When several lines are eligible at once, the one with the smallest number is entered.
- R5: An entry happens only at a clock edge where `insn_boundary` is high, and at most one entry happens per such edge.
- R6: An entry is signalled in the cycle after the deciding edge. `take_pulse` is high for one cycle, `take_addr` holds that line's handler address, and `cur_pc` is saved for that line.
- R7: While contexts are active, a line is eligible only if its number is strictly smaller than the smallest active line number. Requests of equal or lower priority wait.
- R8: A `ret_strobe` while a context is active closes the active context with the smallest number. In the next cycle `ret_valid` pulses high and `ret_addr` holds the address saved when that context was entered.
- R9: A `ret_strobe` while no context is active has no effect on the outputs: `ret_valid` stays 0.
- R10: When `ret_strobe` is high at an edge, no entry happens at that edge, even if `insn_boundary` is high.
- R11: A request still asserted and enabled after its handler has returned is entered again at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 4 | Level-sensitive request per line, bit 0 = line 0 (highest priority) |
| irq_en | input | 4 | Enable per line, same bit order |
| vec_wr | input | 1 | Write strobe for a handler address |
| vec_sel | input | 2 | Line number being written |
| vec_addr | input | ADDR_W | Handler address being written |
| ret_strobe | input | 1 | Return-from-interrupt instruction executed |
| cur_pc | input | ADDR_W | Program counter to save on entry |
| insn_boundary | input | 1 | High when an instruction completes |
| take_pulse | output | 1 | One-cycle entry pulse |
| take_addr | output | ADDR_W | Handler address for the entry |
| ret_valid | output | 1 | One-cycle return pulse |
| ret_addr | output | ADDR_W | Address to resume at after return |

## Verification
The assertions require the core to raise `ret_strobe` and `insn_boundary` only while reset is released, and they hold for any such input pattern. None of them relies on software behaving well, such as returning only from inside a handler. The stimulus deliberately drives boundaries and returns in the same cycle, returns with nothing active, and vector writes in the same cycle as entries. This means the paths that the properties constrain are actually reached. A random phase toggles requests, enables, boundaries and returns independently, and the bench's behavioural model follows the nest through all of it.

// File: rtl/irq_pkg.sv
// Shared constants and types for the nested interrupt controller.
// Assumes a fixed count of four lines; the line index width is derived.
package irq_pkg;
    localparam int unsigned IRQ_LINES = 4;
    localparam int unsigned IRQ_IDX_W = $clog2(IRQ_LINES);

    typedef logic [IRQ_LINES-1:0] irq_mask_t;
    typedef logic [IRQ_IDX_W-1:0] irq_idx_t;

    // Result of a priority search: whether anything was found, and where.
    typedef struct packed {
        logic     found;
        irq_idx_t idx;
    } irq_pick_t;
endpackage

// File: rtl/irq_vec_file.sv
// Handler address storage, one register per line.
// Assumes one write per cycle; the read port shows the value before a same-edge write.
module irq_vec_file
    import irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  irq_idx_t          wr_sel,
    input  logic [ADDR_W-1:0] wr_addr,
    input  irq_idx_t          rd_sel,
    output logic [ADDR_W-1:0] rd_addr
);
    logic [ADDR_W-1:0] vec_q [IRQ_LINES];

    for (genvar g = 0; g < IRQ_LINES; g++) begin : g_vec
        // Hold one line's handler address, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                vec_q[g] <= '0;
            else if (wr_en && (wr_sel == irq_idx_t'(g)))
                vec_q[g] <= wr_addr;
        end
    end

    // Present the selected handler address.
    always_comb rd_addr = vec_q[rd_sel];
endmodule

// File: rtl/irq_arbiter.sv
// Combinational selection of the line to enter.
// Assumes active holds the set of open contexts; only lines strictly above the
// most urgent open context may win, and the smallest number wins among them.
module irq_arbiter
    import irq_pkg::*;
(
    input  irq_mask_t req,
    input  irq_mask_t en,
    input  irq_mask_t active,
    output irq_pick_t pick
);
    irq_mask_t allowed;
    irq_mask_t cand;

    // Mark lines whose number is below every open context.
    always_comb begin
        logic blocked;
        blocked = 1'b0;
        for (int i = 0; i < IRQ_LINES; i++) begin
            if (active[i]) blocked = 1'b1;
            allowed[i] = !blocked;
        end
    end

    // Pick the smallest eligible line number.
    always_comb begin
        cand = req & en & allowed;
        pick = '0;
        for (int i = IRQ_LINES - 1; i >= 0; i--) begin
            if (cand[i]) begin
                pick.found = 1'b1;
                pick.idx   = irq_idx_t'(i);
            end
        end
    end
endmodule

// File: rtl/irq_nest_stack.sv
// Tracks open contexts and the program counter saved for each one.
// Assumes the caller never opens and closes a context at the same edge.
module irq_nest_stack
    import irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_en,
    input  irq_idx_t          open_idx,
    input  logic [ADDR_W-1:0] open_pc,
    input  logic              close_en,
    output irq_mask_t         active,
    output logic              any_active,
    output logic [ADDR_W-1:0] top_pc
);
    irq_mask_t         active_q;
    logic [ADDR_W-1:0] saved_q [IRQ_LINES];
    irq_idx_t          top_idx;

    // Find the innermost context, which is the smallest open line number.
    always_comb begin
        top_idx = '0;
        for (int i = IRQ_LINES - 1; i >= 0; i--)
            if (active_q[i]) top_idx = irq_idx_t'(i);
    end

    for (genvar g = 0; g < IRQ_LINES; g++) begin : g_lvl
        // Open or close this line's context and keep its return address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                active_q[g] <= 1'b0;
                saved_q[g]  <= '0;
            end else if (open_en && (open_idx == irq_idx_t'(g))) begin
                active_q[g] <= 1'b1;
                saved_q[g]  <= open_pc;
            end else if (close_en && (top_idx == irq_idx_t'(g))) begin
                active_q[g] <= 1'b0;
            end
        end
    end

    // Expose the nest state and the innermost return address.
    always_comb begin
        active     = active_q;
        any_active = |active_q;
        top_pc     = saved_q[top_idx];
    end
endmodule

// File: rtl/prio_nest_intc.sv
// Top of the nested four-line priority interrupt controller.
// Assumes the core asserts insn_boundary once per finished instruction and
// ret_strobe when it executes a return; outputs are registered pulses.
module prio_nest_intc
    import irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IRQ_LINES-1:0] irq_req,
    input  logic [IRQ_LINES-1:0] irq_en,
    input  logic                 vec_wr,
    input  logic [IRQ_IDX_W-1:0] vec_sel,
    input  logic [ADDR_W-1:0]    vec_addr,
    input  logic                 ret_strobe,
    input  logic [ADDR_W-1:0]    cur_pc,
    input  logic                 insn_boundary,
    output logic                 take_pulse,
    output logic [ADDR_W-1:0]    take_addr,
    output logic                 ret_valid,
    output logic [ADDR_W-1:0]    ret_addr
);
    irq_mask_t         active;
    logic              any_active;
    logic [ADDR_W-1:0] top_pc;
    logic [ADDR_W-1:0] vec_rd;
    irq_pick_t         pick;
    logic              do_ret;
    logic              do_take;

    irq_vec_file #(.ADDR_W(ADDR_W)) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (vec_wr),
        .wr_sel  (vec_sel),
        .wr_addr (vec_addr),
        .rd_sel  (pick.idx),
        .rd_addr (vec_rd)
    );

    irq_arbiter u_arb (
        .req    (irq_req),
        .en     (irq_en),
        .active (active),
        .pick   (pick)
    );

    irq_nest_stack #(.ADDR_W(ADDR_W)) u_nest (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_en    (do_take),
        .open_idx   (pick.idx),
        .open_pc    (cur_pc),
        .close_en   (do_ret),
        .active     (active),
        .any_active (any_active),
        .top_pc     (top_pc)
    );

    // Decide this edge's action; a return strobe suppresses any entry.
    always_comb begin
        do_ret  = ret_strobe && any_active;
        do_take = insn_boundary && !ret_strobe && pick.found;
    end

    // Register the entry and return pulses with their addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_pulse <= 1'b0;
            take_addr  <= '0;
            ret_valid  <= 1'b0;
            ret_addr   <= '0;
        end else begin
            take_pulse <= do_take;
            ret_valid  <= do_ret;
            if (do_take) take_addr <= vec_rd;
            if (do_ret)  ret_addr  <= top_pc;
        end
    end
endmodule

// File: rtl/prio_nest_intc_chk.sv
// Property checker for the nested interrupt controller, bound to the top.
// Assumes it sees the top's ports plus its open-context mask.
module prio_nest_intc_chk
    import irq_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input irq_mask_t irq_req,
    input irq_mask_t irq_en,
    input logic      ret_strobe,
    input logic      insn_boundary,
    input logic      take_pulse,
    input logic      ret_valid,
    input irq_mask_t active
);
    assert_take_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> $past(insn_boundary));

    assert_take_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> ($past(irq_req & irq_en) != '0));

    assert_ret_blocks_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> !$past(ret_strobe));

    assert_ret_needs_context_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> ($past(ret_strobe) && ($past(active) != '0)));

    assert_entry_opens_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> ($countones(active) == $countones($past(active)) + 1));

    assert_pulses_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_pulse && ret_valid));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !$past(rst_n) |-> (!take_pulse && !ret_valid && active == '0));
endmodule

bind prio_nest_intc prio_nest_intc_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_req       (irq_req),
    .irq_en        (irq_en),
    .ret_strobe    (ret_strobe),
    .insn_boundary (insn_boundary),
    .take_pulse    (take_pulse),
    .ret_valid     (ret_valid),
    .active        (active)
);

// File: tb/test_prio_nest_intc.sv
`timescale 1ns/1ps
module test_prio_nest_intc;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    irq_req = '0;
    logic [3:0]    irq_en = '0;
    logic          vec_wr = 1'b0;
    logic [1:0]    vec_sel = '0;
    logic [AW-1:0] vec_addr = '0;
    logic          ret_strobe = 1'b0;
    logic [AW-1:0] cur_pc = '0;
    logic          insn_boundary = 1'b0;
    logic          take_pulse, ret_valid;
    logic [AW-1:0] take_addr, ret_addr;

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    string tag = "R1";

    prio_nest_intc #(.ADDR_W(AW)) i_prio_nest_intc (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
        .vec_wr(vec_wr), .vec_sel(vec_sel), .vec_addr(vec_addr),
        .ret_strobe(ret_strobe), .cur_pc(cur_pc), .insn_boundary(insn_boundary),
        .take_pulse(take_pulse), .take_addr(take_addr),
        .ret_valid(ret_valid), .ret_addr(ret_addr)
    );

    always #4 clk = ~clk;

    // Behavioural reference model, advanced on each rising edge.
    int m_vec [4];
    int m_sav [4];
    bit m_act [4];
    bit e_take = 0, e_ret = 0;
    int e_taddr = 0, e_raddr = 0;

    always @(posedge clk) begin
        int inner;
        int win;
        e_take = 0;
        e_ret  = 0;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_vec[i] = 0; m_sav[i] = 0; m_act[i] = 0;
            end
        end else begin
            inner = 4;
            for (int i = 3; i >= 0; i--) if (m_act[i]) inner = i;
            if (ret_strobe) begin
                if (inner < 4) begin
                    e_ret = 1; e_raddr = m_sav[inner]; m_act[inner] = 0;
                end
            end else if (insn_boundary) begin
                win = -1;
                for (int i = 0; i < 4; i++)
                    if (win < 0 && i < inner && irq_req[i] && irq_en[i]) win = i;
                if (win >= 0) begin
                    e_take = 1; e_taddr = m_vec[win];
                    m_sav[win] = int'(cur_pc); m_act[win] = 1;
                end
            end
            if (vec_wr) m_vec[vec_sel] = int'(vec_addr);
        end
    end

    // Compare outputs with the model away from the rising edge.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (take_pulse !== e_take || (e_take && int'(take_addr) != e_taddr)) begin
                failures++;
                $display("FAIL %s take: actual pulse=%0b addr=%h expected pulse=%0b addr=%h",
                         tag, take_pulse, take_addr, e_take, e_taddr[AW-1:0]);
            end
            checks++;
            if (ret_valid !== e_ret || (e_ret && int'(ret_addr) != e_raddr)) begin
                failures++;
                $display("FAIL %s ret: actual valid=%0b addr=%h expected valid=%0b addr=%h",
                         tag, ret_valid, ret_addr, e_ret, e_raddr[AW-1:0]);
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    // One cycle with a boundary at the given pc, then quiet.
    task automatic boundary(logic [AW-1:0] pc);
        cur_pc = pc; insn_boundary = 1; tick();
        insn_boundary = 0; tick();
    endtask

    task automatic do_ret();
        ret_strobe = 1; tick();
        ret_strobe = 0; tick();
    endtask

    // Directed check of an expected pulse value, named by requirement.
    task automatic expect_take(string r, logic [AW-1:0] a);
        checks++;
        if (!(take_pulse === 1'b1 && take_addr === a)) begin
            failures++;
            $display("FAIL %s directed take: actual %0b/%h expected 1/%h", r, take_pulse, take_addr, a);
        end
    endtask

    initial begin
        tick(3);
        tag = "R1";
        rst_n = 1; tick(2);

        tag = "R2";
        for (int i = 0; i < 4; i++) begin
            vec_wr = 1; vec_sel = 2'(i); vec_addr = AW'(16'h1000 + i * 16'h100); tick();
        end
        vec_wr = 0; tick();

        tag = "R3";
        irq_req = 4'b1000; irq_en = 4'b0111; boundary(16'h0020);

        tag = "R4";
        irq_req = 4'b1110; irq_en = 4'b1111;
        cur_pc = 16'h0040; insn_boundary = 1; tick();
        insn_boundary = 0; expect_take("R4", 16'h1100);
        irq_req = 4'b0000; tick();

        tag = "R7";
        irq_req = 4'b0110; boundary(16'h0044);
        irq_req = 4'b0001; boundary(16'h0050);

        tag = "R8";
        irq_req = 4'b0000; do_ret(); do_ret();

        tag = "R9";
        do_ret();

        tag = "R10";
        irq_req = 4'b1000; boundary(16'h0060);
        irq_req = 4'b0100;
        cur_pc = 16'h0064; insn_boundary = 1; ret_strobe = 1; tick();
        insn_boundary = 0; ret_strobe = 0; tick();

        tag = "R5";
        irq_req = 4'b0110; tick(3);
        boundary(16'h0070);
        boundary(16'h0072);
        irq_req = 4'b0000;

        tag = "R11";
        irq_req = 4'b0100; do_ret(); do_ret();
        boundary(16'h0080);

        tag = "R6";
        irq_req = 4'b0000; do_ret();
        vec_wr = 1; vec_sel = 2'd0; vec_addr = 16'h2222;
        irq_req = 4'b0001; cur_pc = 16'h0090; insn_boundary = 1; tick();
        vec_wr = 0; insn_boundary = 0; irq_req = 4'b0000; tick();
        do_ret();

        tag = "R7";
        for (int k = 0; k < 3000; k++) begin
            irq_req = 4'($urandom); irq_en = 4'($urandom | 4'b0001);
            insn_boundary = 1'($urandom); ret_strobe = ($urandom % 4) == 0;
            cur_pc = 16'($urandom);
            vec_wr = ($urandom % 8) == 0; vec_sel = 2'($urandom); vec_addr = 16'($urandom);
            tick();
        end
        irq_req = 0; insn_boundary = 0; ret_strobe = 0; vec_wr = 0;
        tick(2);

        tag = "R1";
        rst_n = 0; tick(2);
        rst_n = 1; irq_req = 4'b0010; irq_en = 4'b1111; boundary(16'h00A0);
        tick(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule